// File: doc/BRIEF.md
# Single-Level Paged Address Translator

This block turns a virtual address into a physical address. It keeps one map entry per virtual page in internal storage. The page size is a power of two and is set by a parameter. The low address bits form the in-page offset and pass through unchanged. The remaining upper bits form the virtual page number, which indexes the map directly. Each entry holds the following:

- a physical page number;
- a present flag;
- separate read and write rights for supervisor mode and for user mode;
- a cacheable flag;
- an accessed flag and a dirty flag, which the block maintains itself.

A client offers a request made of an address, a write flag and a user-mode flag. The block takes two cycles to handle it, as a read-modify-write of the entry. In the first cycle it reads the entry, checks it, and forms the physical address or a fault. In the second cycle it presents the response and writes back the updated status flags. During both cycles the block accepts no new request. A side port lets software write whole entries and read them back, including the status flags the block has set.

Top module: `page_xlate`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` is 0, and every map entry reads back as zero, which means not present.
- R2: An entry word is laid out as follows. Bit 0 is present, bit 1 is supervisor read, bit 2 is supervisor write, bit 3 is user read, bit 4 is user write, bit 5 is cacheable, bit 6 is accessed and bit 7 is dirty. Bits [PPN_W+7:8] hold the physical page number. On a permitted access to a present page, `rsp_paddr` is that page number joined above the unchanged low PAGE_BITS bits of the virtual address.
- R3: A request is accepted on an edge where `req_valid` and `req_ready` are both 1. `rsp_valid` is then 1 for exactly one cycle, two edges after the accepting edge. `req_ready` is 0 between the accept and the response, and returns to 1 on the edge after the response.
- R4: An access to an entry whose present bit is 0 gives `rsp_page_fault`=1, with `rsp_paddr`=0 and `rsp_cacheable`=0, and leaves the entry unchanged.
- R5: An access to a present page is allowed only if the entry grants the right that matches both the request mode and the direction. A user request uses the user bits, a supervisor request uses the supervisor bits, a write uses the write bit and a read uses the read bit. A denied access gives `rsp_prot_fault`=1, with `rsp_paddr`=0 and `rsp_cacheable`=0, and leaves the accessed and dirty bits unchanged.
- R6: Every permitted access sets the entry's accessed bit.
- R7: Every permitted write sets the entry's dirty bit. A permitted read leaves the dirty bit as it was.
- R8: On a permitted access, `rsp_cacheable` equals the entry's cacheable bit.
- R9: A software write stores the whole entry word, including the accessed and dirty bits, and overwrites any flags the block has set. `map_rdata` returns the entry at the `map_addr` that was sampled on the previous edge.
- R10: A response never has both fault flags set. A missing page reports a page fault even when the rights are also absent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Translation request offered |
| req_ready | output | 1 | Block is idle and takes a request this cycle |
| req_vaddr | input | VA_W | Virtual address |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_user | input | 1 | 1 = user mode, 0 = supervisor mode |
| rsp_valid | output | 1 | Response fields are valid this cycle |
| rsp_paddr | output | PA_W | Physical address, or 0 on a fault |
| rsp_cacheable | output | 1 | Page may be cached |
| rsp_page_fault | output | 1 | Page is not present |
| rsp_prot_fault | output | 1 | Rights deny this access |
| map_we | input | 1 | Software write of a whole map entry |
| map_addr | input | VPN_W | Entry index for a software read or write |
| map_wdata | input | PPN_W+8 | Entry word to store |
| map_rdata | output | PPN_W+8 | Entry word read back, one cycle of latency |

## Verification
The assertions assume that software writes the map only while the block is idle and no request is being offered in the same cycle. This ensures that no software write can overlap the read-modify-write of an entry. The stimulus keeps to this rule. Every map access is made between completed translations, and requests are held off while the map is written. Within that rule, requests are offered back to back, with `req_valid` held high through the busy cycles. They cover every mode and direction against entries with random rights, and they revisit pages so that the status flags accumulate.

// File: rtl/pgx_pkg.sv
// Package: shared flag layout for map entries.
// Assumes the flag byte sits in the low eight bits of every entry word and
// that the physical page number occupies the bits above it.
package pgx_pkg;

    // Per-page flag byte; the first member is the most significant bit.
    typedef struct packed {
        logic dirty;      // bit 7
        logic accessed;   // bit 6
        logic cacheable;  // bit 5
        logic usr_wr;     // bit 4
        logic usr_rd;     // bit 3
        logic sup_wr;     // bit 2
        logic sup_rd;     // bit 1
        logic present;    // bit 0
    } pg_flags_t;

    localparam int FLAG_W = $bits(pg_flags_t);

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_LOOK = 2'd1,
        SQ_WB   = 2'd2
    } sq_state_t;

endpackage

// File: rtl/pgx_map_store.sv
// Module: page map storage.
// Holds one entry word per virtual page. It provides a combinational lookup
// read, a registered software read, and one write port shared by software
// and hardware write-back. Software wins if both write in the same cycle.
// Assumes the index widths match the number of rows.
module pgx_map_store #(
    parameter int IDX_W = 6,
    parameter int ENT_W = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] lk_idx,
    output logic [ENT_W-1:0] lk_entry,
    input  logic             wb_en,
    input  logic [IDX_W-1:0] wb_idx,
    input  logic [ENT_W-1:0] wb_data,
    input  logic             sw_we,
    input  logic [IDX_W-1:0] sw_idx,
    input  logic [ENT_W-1:0] sw_wdata,
    output logic [ENT_W-1:0] sw_rdata
);

    localparam int ROWS = 1 << IDX_W;

    logic [ENT_W-1:0] cells [ROWS];

    // Pick the write source: a software write has priority over write-back.
    logic             wr_any;
    logic [IDX_W-1:0] wr_idx;
    logic [ENT_W-1:0] wr_word;

    always_comb begin
        wr_any  = sw_we | wb_en;
        wr_idx  = sw_we ? sw_idx   : wb_idx;
        wr_word = sw_we ? sw_wdata : wb_data;
    end

    // One register per row, cleared on reset and loaded when selected.
    for (genvar r = 0; r < ROWS; r++) begin : g_row
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cells[r] <= '0;
            end else if (wr_any && (wr_idx == IDX_W'(r))) begin
                cells[r] <= wr_word;
            end
        end
    end

    // Combinational lookup read for the translation path.
    assign lk_entry = cells[lk_idx];

    // Registered software read-back, which shows the value before this edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sw_rdata <= '0;
        end else begin
            sw_rdata <= cells[sw_idx];
        end
    end

endmodule

// File: rtl/pgx_rights.sv
// Module: presence and rights decision.
// A purely combinational check of one entry's flags against the mode and
// direction of a request. It also produces the flags to write back.
// Assumes the caller writes back next_flags only when granted is 1.
module pgx_rights
    import pgx_pkg::*;
(
    input  pg_flags_t flags,
    input  logic      is_write,
    input  logic      is_user,
    output logic      miss,
    output logic      deny,
    output logic      granted,
    output pg_flags_t next_flags
);

    logic right_ok;

    // Select the single right bit that matches mode and direction.
    always_comb begin
        unique case ({is_user, is_write})
            2'b00:   right_ok = flags.sup_rd;
            2'b01:   right_ok = flags.sup_wr;
            2'b10:   right_ok = flags.usr_rd;
            default: right_ok = flags.usr_wr;
        endcase
    end

    // Absence outranks rights, so at most one fault is reported.
    always_comb begin
        miss    = ~flags.present;
        deny    = flags.present & ~right_ok;
        granted = flags.present & right_ok;
    end

    // Mark the page used, and also dirty when the access is a write.
    always_comb begin
        next_flags          = flags;
        next_flags.accessed = 1'b1;
        next_flags.dirty    = flags.dirty | is_write;
    end

endmodule

// File: rtl/pgx_sequencer.sv
// Module: request sequencer.
// Accepts a request while idle, looks the entry up in the next cycle,
// presents the response and writes the entry back in the cycle after that.
// Assumes the map store lookup is combinational.
module pgx_sequencer
    import pgx_pkg::*;
#(
    parameter int VA_W      = 16,
    parameter int PAGE_BITS = 10,
    parameter int PPN_W     = 10,
    parameter int PA_W      = 20,
    parameter int VPN_W     = 6,
    parameter int ENT_W     = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [VA_W-1:0]  req_vaddr,
    input  logic             req_write,
    input  logic             req_user,
    output logic [VPN_W-1:0] lk_idx,
    input  logic [ENT_W-1:0] lk_entry,
    output logic             hold_write,
    output logic             hold_user,
    input  logic             miss,
    input  logic             deny,
    input  logic             granted,
    input  pg_flags_t        next_flags,
    output logic             wb_en,
    output logic [VPN_W-1:0] wb_idx,
    output logic [ENT_W-1:0] wb_data,
    output logic             rsp_valid,
    output logic [PA_W-1:0]  rsp_paddr,
    output logic             rsp_cacheable,
    output logic             rsp_page_fault,
    output logic             rsp_prot_fault
);

    sq_state_t        state;
    logic [VA_W-1:0]  hold_vaddr;
    logic             wb_pend;
    logic [ENT_W-1:0] wb_word;
    logic [PPN_W-1:0] ent_ppn;
    pg_flags_t        ent_flags;

    // Split the looked-up word into its page number and flag byte.
    always_comb begin
        ent_ppn   = lk_entry[ENT_W-1:FLAG_W];
        ent_flags = pg_flags_t'(lk_entry[FLAG_W-1:0]);
    end

    // Advance IDLE -> LOOK -> WB -> IDLE.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SQ_IDLE;
        end else begin
            unique case (state)
                SQ_IDLE: if (req_valid) state <= SQ_LOOK;
                SQ_LOOK: state <= SQ_WB;
                default: state <= SQ_IDLE;
            endcase
        end
    end

    // Capture the request on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_vaddr <= '0;
            hold_write <= 1'b0;
            hold_user  <= 1'b0;
        end else if (state == SQ_IDLE && req_valid) begin
            hold_vaddr <= req_vaddr;
            hold_write <= req_write;
            hold_user  <= req_user;
        end
    end

    // Register the lookup result and the updated entry during LOOK.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_paddr      <= '0;
            rsp_cacheable  <= 1'b0;
            rsp_page_fault <= 1'b0;
            rsp_prot_fault <= 1'b0;
            wb_pend        <= 1'b0;
            wb_word        <= '0;
        end else if (state == SQ_LOOK) begin
            rsp_paddr      <= granted ? {ent_ppn, hold_vaddr[PAGE_BITS-1:0]} : '0;
            rsp_cacheable  <= granted & ent_flags.cacheable;
            rsp_page_fault <= miss;
            rsp_prot_fault <= deny;
            wb_pend        <= granted;
            wb_word        <= {ent_ppn, next_flags};
        end
    end

    // Drive the handshake, the lookup index and the write-back request.
    always_comb begin
        req_ready = (state == SQ_IDLE);
        rsp_valid = (state == SQ_WB);
        lk_idx    = hold_vaddr[VA_W-1:PAGE_BITS];
        wb_idx    = hold_vaddr[VA_W-1:PAGE_BITS];
        wb_en     = (state == SQ_WB) & wb_pend;
        wb_data   = wb_word;
    end

endmodule

// File: rtl/page_xlate.sv
// Module: single-level paged address translator (top).
// Joins the map store, the rights check and the request sequencer.
// Assumes VA_W > PAGE_BITS and that software writes the map only while
// the block is idle and no request is offered.
module page_xlate
    import pgx_pkg::*;
#(
    parameter int VA_W      = 16,
    parameter int PAGE_BITS = 10,
    parameter int PPN_W     = 10,
    localparam int VPN_W    = VA_W - PAGE_BITS,
    localparam int PA_W     = PPN_W + PAGE_BITS,
    localparam int ENT_W    = PPN_W + FLAG_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [VA_W-1:0]  req_vaddr,
    input  logic             req_write,
    input  logic             req_user,
    output logic             rsp_valid,
    output logic [PA_W-1:0]  rsp_paddr,
    output logic             rsp_cacheable,
    output logic             rsp_page_fault,
    output logic             rsp_prot_fault,
    input  logic             map_we,
    input  logic [VPN_W-1:0] map_addr,
    input  logic [ENT_W-1:0] map_wdata,
    output logic [ENT_W-1:0] map_rdata
);

    logic [VPN_W-1:0] lk_idx;
    logic [ENT_W-1:0] lk_entry;
    logic             wb_en;
    logic [VPN_W-1:0] wb_idx;
    logic [ENT_W-1:0] wb_data;
    logic             hold_write;
    logic             hold_user;
    logic             miss;
    logic             deny;
    logic             granted;
    pg_flags_t        next_flags;
    pg_flags_t        lk_flags;

    // Isolate the flag byte of the looked-up entry for the rights check.
    assign lk_flags = pg_flags_t'(lk_entry[FLAG_W-1:0]);

    pgx_map_store #(
        .IDX_W (VPN_W),
        .ENT_W (ENT_W)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .lk_idx   (lk_idx),
        .lk_entry (lk_entry),
        .wb_en    (wb_en),
        .wb_idx   (wb_idx),
        .wb_data  (wb_data),
        .sw_we    (map_we),
        .sw_idx   (map_addr),
        .sw_wdata (map_wdata),
        .sw_rdata (map_rdata)
    );

    pgx_rights u_rights (
        .flags      (lk_flags),
        .is_write   (hold_write),
        .is_user    (hold_user),
        .miss       (miss),
        .deny       (deny),
        .granted    (granted),
        .next_flags (next_flags)
    );

    pgx_sequencer #(
        .VA_W      (VA_W),
        .PAGE_BITS (PAGE_BITS),
        .PPN_W     (PPN_W),
        .PA_W      (PA_W),
        .VPN_W     (VPN_W),
        .ENT_W     (ENT_W)
    ) u_seq (
        .clk            (clk),
        .rst_n          (rst_n),
        .req_valid      (req_valid),
        .req_ready      (req_ready),
        .req_vaddr      (req_vaddr),
        .req_write      (req_write),
        .req_user       (req_user),
        .lk_idx         (lk_idx),
        .lk_entry       (lk_entry),
        .hold_write     (hold_write),
        .hold_user      (hold_user),
        .miss           (miss),
        .deny           (deny),
        .granted        (granted),
        .next_flags     (next_flags),
        .wb_en          (wb_en),
        .wb_idx         (wb_idx),
        .wb_data        (wb_data),
        .rsp_valid      (rsp_valid),
        .rsp_paddr      (rsp_paddr),
        .rsp_cacheable  (rsp_cacheable),
        .rsp_page_fault (rsp_page_fault),
        .rsp_prot_fault (rsp_prot_fault)
    );

endmodule

// File: rtl/pgx_checker.sv
// Module: property checker for page_xlate, attached by bind.
// Observes only the top-level ports.
module pgx_checker #(
    parameter int VA_W      = 16,
    parameter int PAGE_BITS = 10,
    parameter int PA_W      = 20,
    parameter int VPN_W     = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic [VA_W-1:0]  req_vaddr,
    input logic             rsp_valid,
    input logic [PA_W-1:0]  rsp_paddr,
    input logic             rsp_cacheable,
    input logic             rsp_page_fault,
    input logic             rsp_prot_fault,
    input logic             map_we,
    input logic [VPN_W-1:0] map_addr
);

    logic accept;
    assign accept = req_valid & req_ready;

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> (req_ready && !rsp_valid));

    // R3
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (!req_ready && !rsp_valid));

    // R3
    rsp_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ($past(accept, 2) && !req_ready));

    // R3
    rsp_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> (!rsp_valid && req_ready));

    // R2
    offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_page_fault && !rsp_prot_fault) |->
            (rsp_paddr[PAGE_BITS-1:0] == $past(req_vaddr[PAGE_BITS-1:0], 2)));

    // R4
    miss_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_page_fault) |-> (rsp_paddr == '0 && !rsp_cacheable));

    // R5
    deny_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_prot_fault) |-> (rsp_paddr == '0 && !rsp_cacheable));

    // R10
    one_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !(rsp_page_fault && rsp_prot_fault));

    // R9 (input rule: software writes only while idle and not requested)
    map_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        map_we |-> (req_ready && !req_valid && !$isunknown(map_addr)));

endmodule

bind page_xlate pgx_checker #(
    .VA_W      (VA_W),
    .PAGE_BITS (PAGE_BITS),
    .PA_W      (PA_W),
    .VPN_W     (VPN_W)
) u_pgx_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .req_ready      (req_ready),
    .req_vaddr      (req_vaddr),
    .rsp_valid      (rsp_valid),
    .rsp_paddr      (rsp_paddr),
    .rsp_cacheable  (rsp_cacheable),
    .rsp_page_fault (rsp_page_fault),
    .rsp_prot_fault (rsp_prot_fault),
    .map_we         (map_we),
    .map_addr       (map_addr)
);

// File: tb/sim_page_xlate.sv
module sim_page_xlate;

    localparam int VA_W  = 16;
    localparam int PG_B  = 10;
    localparam int PPN_W = 10;
    localparam int VPN_W = VA_W - PG_B;
    localparam int PA_W  = PPN_W + PG_B;
    localparam int ENT_W = PPN_W + 8;
    localparam int ROWS  = 1 << VPN_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic             req_ready;
    logic [VA_W-1:0]  req_vaddr = '0;
    logic             req_write = 1'b0;
    logic             req_user = 1'b0;
    logic             rsp_valid;
    logic [PA_W-1:0]  rsp_paddr;
    logic             rsp_cacheable;
    logic             rsp_page_fault;
    logic             rsp_prot_fault;
    logic             map_we = 1'b0;
    logic [VPN_W-1:0] map_addr = '0;
    logic [ENT_W-1:0] map_wdata = '0;
    logic [ENT_W-1:0] map_rdata;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    page_xlate #(.VA_W(VA_W), .PAGE_BITS(PG_B), .PPN_W(PPN_W)) u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .req_write(req_write), .req_user(req_user),
        .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_cacheable(rsp_cacheable),
        .rsp_page_fault(rsp_page_fault), .rsp_prot_fault(rsp_prot_fault),
        .map_we(map_we), .map_addr(map_addr), .map_wdata(map_wdata), .map_rdata(map_rdata)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    int m_mem [ROWS];
    int m_stage = 0;
    int m_idx, m_new, m_upd;
    int e_paddr, e_cache, e_pf, e_prot;
    int e_rdata = 0;

    function automatic int right_of(int e, int w, int u);
        if (u != 0) return (w != 0) ? ((e >> 4) & 1) : ((e >> 3) & 1);
        return (w != 0) ? ((e >> 2) & 1) : ((e >> 1) & 1);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (m_mem[i]) m_mem[i] = 0;
            m_stage = 0; e_rdata = 0; m_upd = 0;
        end else begin
            e_rdata = m_mem[int'(map_addr)];
            case (m_stage)
                0: if (req_valid) begin
                    int e;
                    m_idx = int'(req_vaddr) >> PG_B;
                    e = m_mem[m_idx];
                    e_pf = 0; e_prot = 0; e_paddr = 0; e_cache = 0; m_upd = 0;
                    if ((e & 1) == 0) e_pf = 1;
                    else if (right_of(e, int'(req_write), int'(req_user)) == 0) e_prot = 1;
                    else begin
                        e_paddr = ((e >> 8) << PG_B) | (int'(req_vaddr) & ((1 << PG_B) - 1));
                        e_cache = (e >> 5) & 1;
                        m_new = e | 64 | (req_write ? 128 : 0);
                        m_upd = 1;
                    end
                    m_stage = 1;
                end
                1: m_stage = 2;
                default: begin
                    if (m_upd != 0) m_mem[m_idx] = m_new;
                    m_stage = 0;
                end
            endcase
            if (map_we) m_mem[int'(map_addr)] = int'(map_wdata);
        end
    end

    // Compare every cycle, away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R3 req_ready", int'(req_ready), (m_stage == 0) ? 1 : 0);
            chk("R3 rsp_valid", int'(rsp_valid), (m_stage == 2) ? 1 : 0);
            chk("R9 map_rdata", int'(map_rdata), e_rdata);
            if (m_stage == 2 && rsp_valid) begin
                chk("R2 rsp_paddr", int'(rsp_paddr), e_paddr);
                chk("R8 rsp_cacheable", int'(rsp_cacheable), e_cache);
                chk("R4 rsp_page_fault", int'(rsp_page_fault), e_pf);
                chk("R5 rsp_prot_fault", int'(rsp_prot_fault), e_prot);
                chk("R10 single fault", int'(rsp_page_fault & rsp_prot_fault), 0);
            end
        end
    end

    // ---------------- stimulus tasks ----------------
    task automatic map_write(input int idx, input int word);
        @(negedge clk);
        map_we = 1'b1; map_addr = VPN_W'(idx); map_wdata = ENT_W'(word);
        @(negedge clk);
        map_we = 1'b0;
    endtask

    task automatic map_read(input int idx, output int word);
        @(negedge clk);
        map_addr = VPN_W'(idx);
        @(negedge clk);
        word = int'(map_rdata);
    endtask

    task automatic xlate(input int va, input bit w, input bit u);
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = VA_W'(va); req_write = w; req_user = u;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    // Entry word builder: bit0 present, bits1..4 rights, bit5 cacheable.
    function automatic int ent(int ppn, int fl);
        return (ppn << 8) | fl;
    endfunction

    initial begin : watchdog
        while (cycles < 100000) begin
            @(posedge clk);
            cycles++;
        end
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        int rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state and cleared map
        chk("R1 req_ready", int'(req_ready), 1);
        chk("R1 rsp_valid", int'(rsp_valid), 0);
        map_read(0, rd);  chk("R1 entry 0 clear", rd, 0);
        map_read(ROWS - 1, rd); chk("R1 last entry clear", rd, 0);

        // R4 miss on an empty map leaves the entry clear
        xlate(16'h0C34, 1'b0, 1'b0);
        map_read(3, rd); chk("R4 entry untouched", rd, 0);

        // R2 R8 supervisor read of a cacheable page
        map_write(5, ent(10'h2AB, 8'h27));
        xlate((5 << PG_B) | 10'h1F3, 1'b0, 1'b0);
        map_read(5, rd); chk("R6 accessed set on read", (rd >> 6) & 1, 1);
        chk("R7 dirty kept clear on read", (rd >> 7) & 1, 0);

        // R7 supervisor write sets dirty
        xlate((5 << PG_B) | 10'h001, 1'b1, 1'b0);
        map_read(5, rd); chk("R7 dirty set on write", (rd >> 7) & 1, 1);

        // R5 user write denied: user read only, flags remain clear
        map_write(9, ent(10'h155, 8'h0B));
        xlate((9 << PG_B) | 10'h3FF, 1'b1, 1'b1);
        map_read(9, rd); chk("R5 status unchanged", rd, ent(10'h155, 8'h0B));
        xlate((9 << PG_B) | 10'h3FF, 1'b0, 1'b1);
        map_read(9, rd); chk("R6 accessed set by user read", (rd >> 6) & 1, 1);

        // R10 not present but no rights either: page fault only
        map_write(12, ent(10'h3FF, 8'h00));
        xlate(12 << PG_B, 1'b1, 1'b1);

        // R9 software overwrite clears hardware-set flags
        map_write(5, ent(10'h011, 8'h07));
        map_read(5, rd); chk("R9 software overwrite", rd, ent(10'h011, 8'h07));

        // R3 request held high back to back
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = VA_W'((5 << PG_B) | 10'h22); req_write = 1'b0; req_user = 1'b0;
        repeat (7) @(negedge clk);
        req_valid = 1'b0;
        repeat (3) @(negedge clk);

        // Random sweep of entries, modes and directions
        for (int n = 0; n < 400; n++) begin
            if ((n % 8) == 0)
                map_write($urandom_range(0, 7), ent($urandom_range(0, 1023), $urandom_range(0, 255)));
            xlate(($urandom_range(0, 7) << PG_B) | $urandom_range(0, 1023),
                  1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
        end
        for (int i = 0; i < 8; i++) map_read(i, rd);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule